// File: doc/BRIEF.md
# Card Interrupt Steering Router

This block collects the interrupt and status signals of several card sockets and delivers them to the host interrupt pins. Each socket brings three inputs: an active-low, level-sensitive interrupt from a 32-bit card, a ready/interrupt-request line from a 16-bit card, and an active-low status-change line. Per-socket routing bits send that socket's card interrupt to the first PCI interrupt pin, to the second PCI interrupt pin, to one of a set of legacy IRQ lines, or to nowhere. Every destination is the OR of the sources routed to it.

The status-change input has two more uses. In 16-bit operation it can act as a ring input that drives a wake-on-ring output. That output only opens when a global ring-mode bit, the socket's power bit and the socket's ring-enable bit are all set and a global blocking bit is clear. In 32-bit operation the same input can raise a power-management event request. That request stays latched until software clears it by writing 1 to its status bit. All card inputs pass through a parameterised synchronizer before they are used. Software reaches the registers through a synchronous write port and a read port with one cycle of latency.

Top module: `irq_steer_router`

## Requirements
- R1: During reset and right after it, every routing and control register is 0. `inta_n`, `intb_n` and `pme_n` read 1, and `irq_out` and `ring_out` read 0, whatever the card inputs are.
- R2: When socket s is in 32-bit mode (CTRL bit 0 = 1), a low `cb_int_n[s]` is treated as a level. Its destination is asserted SYNC_STAGES clock edges after the input falls. The destination stays asserted for as long as the input is low and deasserts SYNC_STAGES edges after the input rises.
- R3: The routing field STEER[1:0] selects the destination: 0 routes nowhere (masked), 1 drives `inta_n` low, 2 drives `intb_n` low, and 3 drives `irq_out[STEER[7:4]]` high.
- R4: Each destination is the OR of all active sources routed to it. It stays asserted until the last of those sources goes inactive.
- R5: When socket s is in 16-bit mode (CTRL bit 0 = 0) with CTRL bit 1 = 1 (I/O mode), a low `c16_rdy_irq[s]` is an interrupt request. With CTRL bit 1 = 0 (memory mode), the input is ready/busy status only: it raises no interrupt and can be read at STATUS bit 0.
- R6: If the legacy line number in STEER[7:4] is NUM_IRQ or larger, the source is masked and no `irq_out` bit is asserted.
- R7: `ring_out` is 1 exactly when GLOBAL bit 7 = 1, GLOBAL bit 0 = 0, and at least one socket has PWR bit 7 = 1, CTRL bit 7 = 1 and a low synchronized `stschg_n`.
- R8: When a socket has CTRL bit 0 = 1 and CTRL bit 2 = 1, a low `stschg_n` sets that socket's bit in the PME status register (address 4*NUM_SOCK+1) one edge after synchronization. `pme_n` is low while any bit of that register is set, and it stays low after `stschg_n` returns high. In 16-bit mode the input never sets the PME status bit.
- R9: Writing 1 to a PME status bit clears it, unless its source is still active in that cycle. Writing 0 leaves it unchanged.
- R10: Socket s occupies addresses 4s+0 (STEER), 4s+1 (CTRL), 4s+2 (PWR) and 4s+3 (STATUS: bit0 ready level, bit1 32-bit interrupt active, bit2 status-change active). GLOBAL is at 4*NUM_SOCK. A read with `rd_en` presents the register's value on `rdata` after the next edge. Unmapped addresses read 0.
- R11: In 16-bit mode `cb_int_n` has no effect on the interrupt outputs. In 32-bit mode `c16_rdy_irq` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_int_n | input | NUM_SOCK | 32-bit card interrupt per socket, active low, level |
| c16_rdy_irq | input | NUM_SOCK | 16-bit ready (1) / interrupt request (0) per socket |
| stschg_n | input | NUM_SOCK | Status change / ring input per socket, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| inta_n | output | 1 | First PCI interrupt, active low |
| intb_n | output | 1 | Second PCI interrupt, active low |
| irq_out | output | NUM_IRQ | Legacy IRQ lines, active high |
| ring_out | output | 1 | Wake-on-ring output, active high |
| pme_n | output | 1 | Power-management event request, active low |

## Verification
The bench holds a 32-bit interrupt low across many cycles and then releases it. A design that detected edges would drop the interrupt early or latch it after release. It sends two sockets to the same PCI pin and to the same legacy line, then releases them one at a time, which exposes a destination driven by only the last writer. It programs a legacy line number past NUM_IRQ and opens the ring gate one bit at a time, to catch decoding that aliases or a gate missing one term. The PME tests clear the wrong bit, clear the bit while the source is still held, and drive the status-change input in 16-bit mode. A latch that forgot on release, cleared too readily or fired in the wrong mode would show up there.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef enum logic [1:0] {
      DST_NONE   = 2'd0,
      DST_PCI_A  = 2'd1,
      DST_PCI_B  = 2'd2,
      DST_LEGACY = 2'd3
   } irq_dst_e;

   localparam int LINE_W        = 4;
   localparam int REGS_PER_SOCK = 4;
   localparam int IDX_STEER     = 0;
   localparam int IDX_CTRL      = 1;
   localparam int IDX_PWR       = 2;
   localparam int IDX_STAT      = 3;

   typedef struct packed {
      logic [LINE_W-1:0] line;
      irq_dst_e          dst;
      logic              ring_en;
      logic              pme_en;
      logic              io_mode;
      logic              wide_mode;
      logic              ring_pwr;
   } sock_cfg_t;

endpackage

// File: rtl/irq_route_sync.sv
module irq_route_sync #(
   parameter int               WIDTH     = 1,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= RESET_VAL;
            end else begin
               stg_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int NUM_SOCK = 2,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wdata,
   input  logic [2:0]          sock_stat [NUM_SOCK],
   input  logic [NUM_SOCK-1:0] pme_req,
   output sock_cfg_t           cfg [NUM_SOCK],
   output logic                ring_mode,
   output logic                ring_block,
   output logic [NUM_SOCK-1:0] pme_stat,
   output logic [7:0]          rdata
);

   localparam int GLB_MODE_A = NUM_SOCK * REGS_PER_SOCK;
   localparam int GLB_PME_A  = GLB_MODE_A + 1;

   logic [7:0]          steer_q [NUM_SOCK];
   logic [7:0]          ctrl_q  [NUM_SOCK];
   logic [7:0]          pwr_q   [NUM_SOCK];
   logic [7:0]          glb_q;
   logic [NUM_SOCK-1:0] pme_q;
   logic [NUM_SOCK-1:0] pme_clr;
   logic [7:0]          rd_mux;
   logic [7:0]          rdata_q;

   assign pme_clr = (wr_en && addr == ADDR_W'(GLB_PME_A)) ? wdata[NUM_SOCK-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SOCK; s++) begin
            steer_q[s] <= '0;
            ctrl_q[s]  <= '0;
            pwr_q[s]   <= '0;
         end
         glb_q <= '0;
         pme_q <= '0;
      end else begin
         for (int s = 0; s < NUM_SOCK; s++) begin
            if (wr_en && addr == ADDR_W'(s*REGS_PER_SOCK + IDX_STEER)) steer_q[s] <= wdata;
            if (wr_en && addr == ADDR_W'(s*REGS_PER_SOCK + IDX_CTRL))  ctrl_q[s]  <= wdata;
            if (wr_en && addr == ADDR_W'(s*REGS_PER_SOCK + IDX_PWR))   pwr_q[s]   <= wdata;
         end
         if (wr_en && addr == ADDR_W'(GLB_MODE_A)) glb_q <= wdata;
         pme_q <= (pme_q & ~pme_clr) | pme_req;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < NUM_SOCK; s++) begin
         if (addr == ADDR_W'(s*REGS_PER_SOCK + IDX_STEER)) rd_mux = steer_q[s];
         if (addr == ADDR_W'(s*REGS_PER_SOCK + IDX_CTRL))  rd_mux = ctrl_q[s];
         if (addr == ADDR_W'(s*REGS_PER_SOCK + IDX_PWR))   rd_mux = pwr_q[s];
         if (addr == ADDR_W'(s*REGS_PER_SOCK + IDX_STAT))  rd_mux = {5'b0, sock_stat[s]};
      end
      if (addr == ADDR_W'(GLB_MODE_A)) rd_mux = glb_q;
      if (addr == ADDR_W'(GLB_PME_A))  rd_mux = 8'(pme_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   generate
      for (genvar s = 0; s < NUM_SOCK; s++) begin : g_cfg
         assign cfg[s].line      = steer_q[s][7:4];
         assign cfg[s].dst       = irq_dst_e'(steer_q[s][1:0]);
         assign cfg[s].ring_en   = ctrl_q[s][7];
         assign cfg[s].pme_en    = ctrl_q[s][2];
         assign cfg[s].io_mode   = ctrl_q[s][1];
         assign cfg[s].wide_mode = ctrl_q[s][0];
         assign cfg[s].ring_pwr  = pwr_q[s][7];

         // R9
         pme_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pme_q[s] && !pme_clr[s]) |=> pme_q[s]);
         // R8
         pme_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pme_q[s]) |-> $past(pme_req[s]));
      end
   endgenerate

   assign ring_mode  = glb_q[7];
   assign ring_block = glb_q[0];
   assign pme_stat   = pme_q;
   assign rdata      = rdata_q;

endmodule

// File: rtl/irq_route_sock.sv
module irq_route_sock (
   input  logic wide_mode,
   input  logic io_mode,
   input  logic ring_en,
   input  logic ring_pwr,
   input  logic pme_en,
   input  logic cb_act,
   input  logic rdy_lvl,
   input  logic sc_act,
   output logic card_irq,
   output logic ring_req,
   output logic pme_req
);

   always_comb begin
      if (wide_mode) card_irq = cb_act;
      else           card_irq = io_mode & ~rdy_lvl;
   end

   assign ring_req = ring_en & ring_pwr & sc_act;
   assign pme_req  = wide_mode & pme_en & sc_act;

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
   import irq_route_pkg::*;
#(
   parameter int NUM_SOCK = 2,
   parameter int NUM_IRQ  = 12
) (
   input  logic [NUM_SOCK-1:0] card_irq,
   input  irq_dst_e            dst  [NUM_SOCK],
   input  logic [LINE_W-1:0]   line [NUM_SOCK],
   output logic                inta_n,
   output logic                intb_n,
   output logic [NUM_IRQ-1:0]  irq_out
);

   logic [NUM_SOCK-1:0] to_a, to_b, to_leg;

   generate
      for (genvar s = 0; s < NUM_SOCK; s++) begin : g_src
         assign to_a[s]   = card_irq[s] && dst[s] == DST_PCI_A;
         assign to_b[s]   = card_irq[s] && dst[s] == DST_PCI_B;
         assign to_leg[s] = card_irq[s] && dst[s] == DST_LEGACY;
      end
      for (genvar l = 0; l < NUM_IRQ; l++) begin : g_line
         logic [NUM_SOCK-1:0] hit;
         for (genvar s = 0; s < NUM_SOCK; s++) begin : g_hit
            assign hit[s] = to_leg[s] && line[s] == LINE_W'(l);
         end
         assign irq_out[l] = |hit;
      end
   endgenerate

   assign inta_n = ~|to_a;
   assign intb_n = ~|to_b;

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
   import irq_route_pkg::*;
#(
   parameter int NUM_SOCK    = 2,
   parameter int NUM_IRQ     = 12,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SOCK-1:0] cb_int_n,
   input  logic [NUM_SOCK-1:0] c16_rdy_irq,
   input  logic [NUM_SOCK-1:0] stschg_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata,
   output logic                inta_n,
   output logic                intb_n,
   output logic [NUM_IRQ-1:0]  irq_out,
   output logic                ring_out,
   output logic                pme_n
);

   localparam int IN_W = 3 * NUM_SOCK;

   generate
      if (NUM_SOCK < 1 || NUM_SOCK > 8) begin : g_bad_sock
         $error("NUM_SOCK must lie in 1..8");
      end
      if (NUM_IRQ < 1 || NUM_IRQ > (1 << LINE_W)) begin : g_bad_irq
         $error("NUM_IRQ exceeds the legacy line field");
      end
      if ((1 << ADDR_W) < NUM_SOCK*REGS_PER_SOCK + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [IN_W-1:0]     raw_in, syn_in;
   logic [NUM_SOCK-1:0] cb_act, rdy_lvl, sc_act;
   logic [NUM_SOCK-1:0] card_irq, ring_req, pme_req, pme_stat;
   logic [2:0]          sock_stat [NUM_SOCK];
   sock_cfg_t           cfg       [NUM_SOCK];
   irq_dst_e            dst       [NUM_SOCK];
   logic [LINE_W-1:0]   line      [NUM_SOCK];
   logic                ring_mode, ring_block;

   assign raw_in = {stschg_n, c16_rdy_irq, cb_int_n};

   irq_route_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RESET_VAL({IN_W{1'b1}})) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign cb_act  = ~syn_in[NUM_SOCK-1:0];
   assign rdy_lvl =  syn_in[2*NUM_SOCK-1:NUM_SOCK];
   assign sc_act  = ~syn_in[3*NUM_SOCK-1:2*NUM_SOCK];

   irq_route_regs #(.NUM_SOCK(NUM_SOCK), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .sock_stat(sock_stat), .pme_req(pme_req), .cfg(cfg),
      .ring_mode(ring_mode), .ring_block(ring_block), .pme_stat(pme_stat),
      .rdata(rdata)
   );

   generate
      for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
         assign sock_stat[s] = {sc_act[s], cb_act[s], rdy_lvl[s]};
         assign dst[s]       = cfg[s].dst;
         assign line[s]      = cfg[s].line;
         irq_route_sock u_sock (
            .wide_mode(cfg[s].wide_mode), .io_mode(cfg[s].io_mode),
            .ring_en(cfg[s].ring_en), .ring_pwr(cfg[s].ring_pwr),
            .pme_en(cfg[s].pme_en), .cb_act(cb_act[s]), .rdy_lvl(rdy_lvl[s]),
            .sc_act(sc_act[s]), .card_irq(card_irq[s]), .ring_req(ring_req[s]),
            .pme_req(pme_req[s])
         );
      end
   endgenerate

   irq_route_merge #(.NUM_SOCK(NUM_SOCK), .NUM_IRQ(NUM_IRQ)) u_merge (
      .card_irq(card_irq), .dst(dst), .line(line),
      .inta_n(inta_n), .intb_n(intb_n), .irq_out(irq_out)
   );

   assign ring_out = ring_mode & ~ring_block & (|ring_req);
   assign pme_n    = ~|pme_stat;

   logic [NUM_SOCK-1:0] want_a, want_b;
   always_comb begin
      for (int s = 0; s < NUM_SOCK; s++) begin
         want_a[s] = card_irq[s] && cfg[s].dst == DST_PCI_A;
         want_b[s] = card_irq[s] && cfg[s].dst == DST_PCI_B;
      end
   end

   // R3
   inta_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_n |-> (|want_a));
   // R4
   intb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|want_b) |-> !intb_n);
   // R7
   ring_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_out |-> (ring_mode && !ring_block));
   // R1
   idle_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (inta_n && intb_n && pme_n && !ring_out && irq_out == '0));

endmodule

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;
   localparam int NI = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] cb_int_n = '1;
   logic [NS-1:0] c16_rdy_irq = '1;
   logic [NS-1:0] stschg_n = '1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [3:0]    addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          inta_n, intb_n, ring_out, pme_n;
   logic [NI-1:0] irq_out;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_steer_router u_dut (
      .clk(clk), .rst_n(rst_n), .cb_int_n(cb_int_n), .c16_rdy_irq(c16_rdy_irq),
      .stschg_n(stschg_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .inta_n(inta_n), .intb_n(intb_n),
      .irq_out(irq_out), .ring_out(ring_out), .pme_n(pme_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      d = rdata;
      rd_en = 1'b0;
   endtask

   function automatic logic [31:0] outs();
      return {16'(irq_out), 12'd0, inta_n, intb_n, ring_out, pme_n};
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      cb_int_n = '0; stschg_n = '0; c16_rdy_irq = '0;
      tick(3);
      chk("R1 in reset", outs(), 32'h0000_000D);
      rst_n = 1'b1;
      tick(4);
      chk("R1 after reset", outs(), 32'h0000_000D);
      rd(4'd0, d);
      chk("R1 steer zero", d, 8'h00);
      cb_int_n = '1; stschg_n = '1; c16_rdy_irq = '1;
      tick(3);
   endtask

   task automatic t_readback();
      logic [7:0] d;
      wr(4'd0, 8'h51); rd(4'd0, d); chk("R10 steer0", d, 8'h51);
      wr(4'd5, 8'h86); rd(4'd5, d); chk("R10 ctrl1", d, 8'h86);
      wr(4'd8, 8'h81); rd(4'd8, d); chk("R10 global", d, 8'h81);
      rd(4'd11, d); chk("R10 unmapped", d, 8'h00);
      c16_rdy_irq[0] = 1'b0; tick(2);
      rd(4'd3, d); chk("R10 status0", d, 8'h00);
      c16_rdy_irq[0] = 1'b1; tick(2);
      rd(4'd3, d); chk("R10 status0 ready", d, 8'h01);
      wr(4'd0, 8'h00); wr(4'd5, 8'h00); wr(4'd8, 8'h00);
   endtask

   task automatic t_level();
      wr(4'd1, 8'h01); wr(4'd0, 8'h01);
      cb_int_n[0] = 1'b0;
      tick(1); chk("R2 latency", inta_n, 1'b1);
      tick(1); chk("R2 asserted", inta_n, 1'b0);
      tick(6); chk("R2 held level", inta_n, 1'b0);
      wr(4'd0, 8'h02);
      chk("R3 to intb a", inta_n, 1'b1);
      chk("R3 to intb b", intb_n, 1'b0);
      wr(4'd0, 8'h00);
      chk("R3 masked", {inta_n, intb_n, 16'(irq_out)}, {2'b11, 16'h0});
      wr(4'd0, 8'h01);
      cb_int_n[0] = 1'b1;
      tick(1); chk("R2 release latency", inta_n, 1'b0);
      tick(1); chk("R2 released", inta_n, 1'b1);
   endtask

   task automatic t_legacy();
      cb_int_n[0] = 1'b0; tick(2);
      wr(4'd0, 8'h53);
      chk("R3 legacy line 5", irq_out, 12'h020);
      wr(4'd0, 8'hB3);
      chk("R3 legacy line 11", irq_out, 12'h800);
      wr(4'd0, 8'hD3);
      chk("R6 line 13 masked", {inta_n, intb_n, 16'(irq_out)}, {2'b11, 16'h0});
      cb_int_n[0] = 1'b1; tick(2);
      wr(4'd0, 8'h00); wr(4'd1, 8'h00);
   endtask

   task automatic t_or();
      wr(4'd1, 8'h01); wr(4'd5, 8'h01);
      wr(4'd0, 8'h01); wr(4'd4, 8'h01);
      cb_int_n = 2'b00; tick(2);
      chk("R4 both on a", inta_n, 1'b0);
      cb_int_n[0] = 1'b1; tick(2);
      chk("R4 one left", inta_n, 1'b0);
      cb_int_n[1] = 1'b1; tick(2);
      chk("R4 none left", inta_n, 1'b1);
      wr(4'd0, 8'h73); wr(4'd4, 8'h73);
      cb_int_n = 2'b00; tick(2);
      cb_int_n[1] = 1'b1; tick(2);
      chk("R4 shared legacy", irq_out, 12'h080);
      cb_int_n[0] = 1'b1; tick(2);
      chk("R4 shared legacy off", irq_out, 12'h000);
      wr(4'd0, 8'h00); wr(4'd4, 8'h00); wr(4'd1, 8'h00); wr(4'd5, 8'h00);
   endtask

   task automatic t_16bit();
      logic [7:0] d;
      wr(4'd5, 8'h02); wr(4'd4, 8'h02);
      c16_rdy_irq[1] = 1'b0; tick(2);
      chk("R5 io request", intb_n, 1'b0);
      wr(4'd5, 8'h00);
      chk("R5 memory no irq", intb_n, 1'b1);
      rd(4'd7, d);
      chk("R5 busy readable", d[0], 1'b0);
      c16_rdy_irq[1] = 1'b1;
      wr(4'd5, 8'h02);
      cb_int_n[1] = 1'b0; tick(3);
      chk("R11 cb ignored 16bit", intb_n, 1'b1);
      cb_int_n[1] = 1'b1;
      wr(4'd5, 8'h01);
      c16_rdy_irq[1] = 1'b0; tick(3);
      chk("R11 rdy ignored 32bit", intb_n, 1'b1);
      c16_rdy_irq[1] = 1'b1; tick(2);
      wr(4'd4, 8'h00); wr(4'd5, 8'h00);
   endtask

   task automatic t_ring();
      wr(4'd8, 8'h80); wr(4'd2, 8'h80); wr(4'd1, 8'h80);
      stschg_n[0] = 1'b0;
      tick(1); chk("R7 latency", ring_out, 1'b0);
      tick(1); chk("R7 all gates open", ring_out, 1'b1);
      chk("R8 no pme 16bit", pme_n, 1'b1);
      wr(4'd8, 8'h81); chk("R7 blocked", ring_out, 1'b0);
      wr(4'd8, 8'h00); chk("R7 mode off", ring_out, 1'b0);
      wr(4'd8, 8'h80); wr(4'd2, 8'h00); chk("R7 pwr off", ring_out, 1'b0);
      wr(4'd2, 8'h80); wr(4'd1, 8'h00); chk("R7 ring en off", ring_out, 1'b0);
      wr(4'd1, 8'h80); chk("R7 reopened", ring_out, 1'b1);
      stschg_n[0] = 1'b1; tick(2);
      chk("R7 input idle", ring_out, 1'b0);
      wr(4'd8, 8'h00); wr(4'd2, 8'h00); wr(4'd1, 8'h00);
   endtask

   task automatic t_pme();
      logic [7:0] d;
      wr(4'd5, 8'h05);
      stschg_n[1] = 1'b0;
      tick(2); chk("R8 not yet", pme_n, 1'b1);
      tick(1); chk("R8 raised", pme_n, 1'b0);
      wr(4'd9, 8'h02);
      chk("R9 held source wins", pme_n, 1'b0);
      stschg_n[1] = 1'b1; tick(4);
      chk("R8 latched", pme_n, 1'b0);
      rd(4'd9, d); chk("R8 status bit", d, 8'h02);
      wr(4'd9, 8'h01);
      chk("R9 wrong bit", pme_n, 1'b0);
      wr(4'd9, 8'h00);
      chk("R9 zero write", pme_n, 1'b0);
      wr(4'd9, 8'h02);
      chk("R9 cleared", pme_n, 1'b1);
      wr(4'd5, 8'h04);
      stschg_n[1] = 1'b0; tick(4);
      chk("R8 16bit no pme", pme_n, 1'b1);
      stschg_n[1] = 1'b1; tick(2);
      wr(4'd5, 8'h00);
   endtask

   initial begin
      t_reset();
      t_readback();
      t_level();
      t_legacy();
      t_or();
      t_16bit();
      t_ring();
      t_pme();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule